// File: doc/BRIEF.md
# Prefetch Engine Control and Interrupt Register Block

This block is the register front end of a NAND prefetch/postwrite data engine. A host writes a configuration word, a transfer count and a start/stop bit over a simple address/data bus. The block decodes the configuration into control fields for the engine. It also decides which chip-select window is routed to the engine's FIFO. When the host starts or stops the engine, the block issues one-cycle command pulses. The engine reports its FIFO fill level, its remaining count and a terminal-count event back to the block.

A two-state sequencer tracks whether the engine is running. The states are `PF_IDLE` and `PF_RUN`. The "start" transition goes from `PF_IDLE` to `PF_RUN` on a control write with bit 0 set. The "forced stop" transition goes from `PF_RUN` to `PF_IDLE` on a control write with bit 0 clear. The "terminal count" transition goes from `PF_RUN` to `PF_IDLE` on an engine terminal-count event. Every other input leaves the state where it is.

Two status bits feed one registered interrupt line through an enable mask. The threshold bit follows the FIFO level. The terminal-count bit is set by an event. The host clears either bit by writing 1 to it.

Top module: `pfx_ctrl_regs`

Register map (word address on `bus_addr`):
- 0: configuration word
- 1: transfer count
- 2: control (bit 0)
- 3: status, write 1 to clear (bit 0 threshold, bit 1 terminal count)
- 4: interrupt enable (bits 1:0)
- 5: read-only engine view, fill level in bits 6:0 and remaining count in bits 29:16

Any other address reads as 0.

## Requirements
- R1: After reset:
  - configuration, count, status and enable registers are 0;
  - the sequencer is in `PF_IDLE`;
  - `irq`, `eng_start`, `eng_stop` and `win_sel` are 0.
- R2: A write to address 0 stores the data ANDed with 0x7F8F7FBF, and address 0 reads it back. The fields decode as follows:
  - bit 0 is write mode (`cfg_write_mode`);
  - bit 2 enables DMA (`cfg_dma_en`);
  - bits 14:8 are the threshold;
  - bits 26:24 are the chip select.
- R3: A write to address 1 keeps the low 14 bits of the data, and address 1 reads them back. The stored count is driven on `eng_load_count`.
- R4: While the sequencer is in `PF_RUN`, writes to address 0 and address 1 change nothing.
- R5: A write to address 2 with bit 0 set while in `PF_IDLE` enters `PF_RUN`. In the cycle after that write, `eng_start` is high for one cycle and `eng_running` is high. `eng_load_fill` equals 64 in write mode and 0 in read mode. `eng_fill_req` pulses together with `eng_start` only in read mode.
- R6: A write to address 2 with bit 0 clear while in `PF_RUN` returns to `PF_IDLE`. It pulses `eng_stop` for one cycle in the following cycle, so that the engine drops its remaining count.
- R7: A control write whose bit 0 equals the current running state produces no pulse and no state change.
- R8: Status bit 0 is set one cycle after `eng_fill` is at least the threshold. Writing 1 to it clears it for one cycle. It is set again on the next cycle if the condition still holds.
- R9: An `eng_tc` pulse in `PF_RUN` sets status bit 1 and returns to `PF_IDLE`, with no `eng_stop` pulse. In `PF_IDLE`, `eng_tc` is ignored. Writing 1 to status bit 1 clears it.
- R10: `irq` is the registered OR of (enable AND status) and follows that value one cycle later.
- R11: `win_sel` is one-hot at the configured chip select when configuration bit 7 is set, and all zero otherwise.
- R12: Address 2 reads the running state in bit 0. Address 5 reads `eng_fill` in bits 6:0 and `eng_remaining` in bits 29:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_fill | input | FILL_W | FIFO fill level from the engine |
| eng_remaining | input | CNT_W | Remaining transfer count from the engine |
| eng_tc | input | 1 | Terminal-count event from the engine |
| eng_running | output | 1 | Sequencer is in `PF_RUN` |
| eng_start | output | 1 | One-cycle start command |
| eng_stop | output | 1 | One-cycle forced-stop command |
| eng_fill_req | output | 1 | One-cycle fill request on a read-mode start |
| eng_load_count | output | CNT_W | Count the engine loads on start |
| eng_load_fill | output | FILL_W | Initial fill level the engine loads on start |
| cfg_write_mode | output | 1 | 1 = postwrite, 0 = prefetch |
| cfg_dma_en | output | 1 | DMA request enable |
| cfg_threshold | output | 7 | FIFO threshold |
| cfg_cs | output | 3 | Selected chip select |
| win_sel | output | NCS | FIFO window select per chip select |
| irq | output | 1 | Interrupt line |

## Verification
The sequencer is driven through each of its transitions:
- a read-mode start and a write-mode start, which tell apart the two initial fill values and show whether the fill request appears;
- a forced stop against a terminal-count stop, which differ in the `eng_stop` pulse;
- redundant control writes in both states, which should do nothing.

The configuration and count registers are written once in `PF_IDLE` and again in `PF_RUN`, which shows the lock. The FIFO level is held above and then below the threshold while status bit 0 is cleared, which separates the level-driven rearm from the event-set terminal-count bit. The interrupt is watched one cycle behind the status.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    typedef enum logic {PF_IDLE, PF_RUN} pf_state_e;

    localparam logic [31:0] CFG_MASK = 32'h7F8F_7FBF;
    localparam int CFG_WMODE_BIT = 0;
    localparam int CFG_DMA_BIT   = 2;
    localparam int CFG_EN_BIT    = 7;
    localparam int CFG_THR_LSB   = 8;
    localparam int THR_W         = 7;
    localparam int CFG_CS_LSB    = 24;
    localparam int CS_W          = 3;

    localparam int A_CFG  = 0;
    localparam int A_CNT  = 1;
    localparam int A_CTRL = 2;
    localparam int A_STAT = 3;
    localparam int A_IEN  = 4;
    localparam int A_ENG  = 5;
endpackage

// File: rtl/pfx_cfg_bank.sv
module pfx_cfg_bank
    import pfx_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             cfg_we,
    input  logic             cnt_we,
    input  logic [31:0]      wdata,
    output logic [31:0]      cfg_q,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we && !lock) begin
            cfg_q <= wdata & CFG_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we && !lock) begin
            cnt_q <= wdata[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/pfx_seq.sv
module pfx_seq
    import pfx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic ctrl_bit,
    input  logic tc_evt,
    output logic running,
    output logic start_p,
    output logic stop_p,
    output logic tc_hit
);
    pf_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_IDLE: if (ctrl_we && ctrl_bit) state_d = PF_RUN;
            PF_RUN:  if (tc_evt || (ctrl_we && !ctrl_bit)) state_d = PF_IDLE;
            default: state_d = PF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PF_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_p <= 1'b0;
            stop_p  <= 1'b0;
        end else begin
            start_p <= (state_q == PF_IDLE) && (state_d == PF_RUN);
            stop_p  <= (state_q == PF_RUN) && !tc_evt && (state_d == PF_IDLE);
        end
    end

    assign running = (state_q == PF_RUN);
    assign tc_hit  = (state_q == PF_RUN) && tc_evt;
endmodule

// File: rtl/pfx_irq_unit.sv
module pfx_irq_unit
    import pfx_pkg::*;
#(
    parameter int FILL_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    input  logic [THR_W-1:0]  thr,
    input  logic              tc_hit,
    input  logic              st_we,
    input  logic              en_we,
    input  logic [1:0]        wbits,
    output logic [1:0]        st_q,
    output logic [1:0]        en_q,
    output logic              irq
);
    logic level_ok;
    assign level_ok = 32'(fill) >= 32'(thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            en_q <= '0;
            irq  <= 1'b0;
        end else begin
            if (st_we && wbits[0]) st_q[0] <= 1'b0;
            else if (level_ok)     st_q[0] <= 1'b1;
            if (tc_hit)                 st_q[1] <= 1'b1;
            else if (st_we && wbits[1]) st_q[1] <= 1'b0;
            if (en_we) en_q <= wbits;
            if (irq != |(en_q & st_q)) irq <= |(en_q & st_q);
        end
    end
endmodule

// File: rtl/pfx_ctrl_regs.sv
module pfx_ctrl_regs
    import pfx_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int CNT_W      = 14,
    parameter int FIFO_DEPTH = 64,
    parameter int NCS        = 8,
    localparam int FILL_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [FILL_W-1:0] eng_fill,
    input  logic [CNT_W-1:0]  eng_remaining,
    input  logic              eng_tc,
    output logic              eng_running,
    output logic              eng_start,
    output logic              eng_stop,
    output logic              eng_fill_req,
    output logic [CNT_W-1:0]  eng_load_count,
    output logic [FILL_W-1:0] eng_load_fill,
    output logic              cfg_write_mode,
    output logic              cfg_dma_en,
    output logic [THR_W-1:0]  cfg_threshold,
    output logic [CS_W-1:0]   cfg_cs,
    output logic [NCS-1:0]    win_sel,
    output logic              irq
);
    logic [31:0]      cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       st_q, en_q;
    logic             tc_hit;
    logic             we_cfg, we_cnt, we_ctrl, we_stat, we_ien;

    assign we_cfg  = bus_we && (32'(bus_addr) == A_CFG);
    assign we_cnt  = bus_we && (32'(bus_addr) == A_CNT);
    assign we_ctrl = bus_we && (32'(bus_addr) == A_CTRL);
    assign we_stat = bus_we && (32'(bus_addr) == A_STAT);
    assign we_ien  = bus_we && (32'(bus_addr) == A_IEN);

    pfx_cfg_bank #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .lock(eng_running),
        .cfg_we(we_cfg), .cnt_we(we_cnt), .wdata(bus_wdata),
        .cfg_q(cfg_q), .cnt_q(cnt_q)
    );

    pfx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_we(we_ctrl), .ctrl_bit(bus_wdata[0]),
        .tc_evt(eng_tc), .running(eng_running), .start_p(eng_start),
        .stop_p(eng_stop), .tc_hit(tc_hit)
    );

    pfx_irq_unit #(.FILL_W(FILL_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .fill(eng_fill), .thr(cfg_threshold),
        .tc_hit(tc_hit), .st_we(we_stat), .en_we(we_ien),
        .wbits(bus_wdata[1:0]), .st_q(st_q), .en_q(en_q), .irq(irq)
    );

    assign cfg_write_mode = cfg_q[CFG_WMODE_BIT];
    assign cfg_dma_en     = cfg_q[CFG_DMA_BIT];
    assign cfg_threshold  = cfg_q[CFG_THR_LSB +: THR_W];
    assign cfg_cs         = cfg_q[CFG_CS_LSB +: CS_W];
    assign eng_load_count = cnt_q;
    assign eng_load_fill  = cfg_write_mode ? FILL_W'(FIFO_DEPTH) : '0;
    assign eng_fill_req   = eng_start && !cfg_write_mode;

    for (genvar g = 0; g < NCS; g++) begin : g_win
        assign win_sel[g] = cfg_q[CFG_EN_BIT] && (32'(cfg_cs) == g);
    end

    always_comb begin
        bus_rdata = '0;
        case (32'(bus_addr))
            A_CFG:   bus_rdata = cfg_q;
            A_CNT:   bus_rdata = 32'(cnt_q);
            A_CTRL:  bus_rdata = {31'b0, eng_running};
            A_STAT:  bus_rdata = {30'b0, st_q};
            A_IEN:   bus_rdata = {30'b0, en_q};
            A_ENG:   bus_rdata = 32'(eng_fill) | (32'(eng_remaining) << 16);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pfx_ctrl_regs_chk.sv
module pfx_ctrl_regs_chk #(
    parameter int CNT_W = 14,
    parameter int NCS   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eng_running,
    input logic             eng_start,
    input logic             eng_stop,
    input logic             eng_tc,
    input logic [CNT_W-1:0] eng_load_count,
    input logic [NCS-1:0]   win_sel,
    input logic             irq,
    input logic [1:0]       st_q,
    input logic [1:0]       en_q
);
    p_start_enters_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $rose(eng_running));

    p_stop_leaves_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_stop |-> $fell(eng_running));

    p_no_pulse_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_start && eng_stop));

    p_count_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eng_running) |-> $stable(eng_load_count));

    p_tc_sets_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eng_running && eng_tc) |-> (st_q[1] && !eng_running && !eng_stop));

    p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(en_q & st_q)));

    p_window_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_sel));
endmodule

bind pfx_ctrl_regs pfx_ctrl_regs_chk #(.CNT_W(CNT_W), .NCS(NCS)) u_chk (
    .clk(clk), .rst_n(rst_n), .eng_running(eng_running), .eng_start(eng_start),
    .eng_stop(eng_stop), .eng_tc(eng_tc), .eng_load_count(eng_load_count),
    .win_sel(win_sel), .irq(irq), .st_q(st_q), .en_q(en_q)
);

// File: tb/pfx_ctrl_regs_test.sv
`timescale 1ns/1ps
module pfx_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  eng_fill = '0;
    logic [13:0] eng_remaining = '0;
    logic        eng_tc = 1'b0;
    logic        eng_running, eng_start, eng_stop, eng_fill_req;
    logic [13:0] eng_load_count;
    logic [6:0]  eng_load_fill;
    logic        cfg_write_mode, cfg_dma_en;
    logic [6:0]  cfg_threshold;
    logic [2:0]  cfg_cs;
    logic [7:0]  win_sel;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pfx_ctrl_regs uut (.*);

    // behavioural reference model
    int m_cfg = 0, m_cnt = 0, m_st = 0, m_en = 0;
    bit m_run = 0, m_start = 0, m_stop = 0, m_irq = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = 0; m_cnt = 0; m_st = 0; m_en = 0;
            m_run = 0; m_start = 0; m_stop = 0; m_irq = 0;
        end else begin
            int a, w, thr, st_n;
            bit run_n;
            a = bus_addr; w = bus_wdata; thr = (m_cfg >> 8) & 127;
            m_irq = (m_en & m_st) != 0;
            st_n = m_st;
            if (bus_we && a == 3 && w[0]) st_n = st_n & 2;
            else if (eng_fill >= thr)     st_n = st_n | 1;
            if (m_run && eng_tc)          st_n = st_n | 2;
            else if (bus_we && a == 3 && w[1]) st_n = st_n & 1;
            if (bus_we && a == 4) m_en = w & 3;
            m_start = 0; m_stop = 0; run_n = m_run;
            if (m_run) begin
                if (eng_tc) run_n = 0;
                else if (bus_we && a == 2 && !w[0]) begin run_n = 0; m_stop = 1; end
            end else if (bus_we && a == 2 && w[0]) begin
                run_n = 1; m_start = 1;
            end
            if (!m_run && bus_we && a == 0) m_cfg = w & 32'h7F8F7FBF;
            if (!m_run && bus_we && a == 1) m_cnt = w & 16'h3FFF;
            m_st = st_n;
            m_run = run_n;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_rdata();
        case (bus_addr)
            3'd0: return m_cfg;
            3'd1: return m_cnt;
            3'd2: return {31'b0, m_run};
            3'd3: return m_st;
            3'd4: return m_en;
            3'd5: return 32'(eng_fill) | (32'(eng_remaining) << 16);
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) if (!done) begin
        int cs;
        cs = (m_cfg >> 24) & 7;
        chk("R12 rdata", bus_rdata, m_rdata());
        chk("R2 cfg fields", {cfg_cs, cfg_threshold, cfg_dma_en, cfg_write_mode},
            {cs[2:0], 7'((m_cfg >> 8) & 127), m_cfg[2], m_cfg[0]});
        chk("R3 load count", 32'(eng_load_count), m_cnt);
        chk("R5 running", 32'(eng_running), 32'(m_run));
        chk("R5 start", {eng_start, eng_fill_req}, {m_start, m_start & !m_cfg[0]});
        chk("R5 load fill", 32'(eng_load_fill), m_cfg[0] ? 64 : 0);
        chk("R6 stop", 32'(eng_stop), 32'(m_stop));
        chk("R10 irq", 32'(irq), 32'(m_irq));
        chk("R11 win_sel", 32'(win_sel), m_cfg[7] ? (1 << cs) : 0);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_we = 1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 0;
    endtask

    task automatic rd(input int a, input string tag, input logic [31:0] exp);
        bus_addr = 3'(a);
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset outputs", {irq, eng_start, eng_stop, eng_running, win_sel}, 0);
        rd(0, "R1 reset cfg", 0);
        rd(3, "R1 reset status", 0);
        rst_n = 1;
        tick(1);
        wr(0, 32'hFFFF_FFFF);
        rd(0, "R2 cfg mask", 32'h7F8F_7FBF);
        wr(0, 32'h0500_1084);
        chk("R11 window cs5", 32'(win_sel), 32'h20);
        chk("R2 threshold", 32'(cfg_threshold), 16);
        wr(1, 32'h0000_FFFF);
        rd(1, "R3 count mask", 32'h3FFF);
        wr(1, 100);
        wr(4, 3);
        wr(2, 1);
        chk("R5 read start", {eng_start, eng_fill_req, eng_running}, 3'b111);
        chk("R5 read fill", 32'(eng_load_fill), 0);
        chk("R5 load count", 32'(eng_load_count), 100);
        tick(1);
        chk("R5 start one cycle", 32'(eng_start), 0);
        wr(0, 32'h0000_0081);
        rd(0, "R4 cfg locked", 32'h0500_1084);
        wr(1, 7);
        rd(1, "R4 count locked", 100);
        wr(2, 1);
        chk("R7 restart ignored", {eng_start, eng_running}, 2'b01);
        eng_fill = 20; eng_remaining = 44;
        tick(1);
        rd(3, "R8 level set", 1);
        rd(5, "R12 engine view", 32'd20 | (32'd44 << 16));
        tick(1);
        chk("R10 irq raised", 32'(irq), 1);
        wr(3, 1);
        rd(3, "R8 w1c clears", 0);
        tick(1);
        rd(3, "R8 level rearms", 1);
        eng_fill = 5;
        wr(3, 1);
        tick(2);
        rd(3, "R8 stays clear", 0);
        chk("R10 irq dropped", 32'(irq), 0);
        @(negedge clk); #1; eng_tc = 1;
        tick(1); eng_tc = 0;
        chk("R9 tc ends run", {eng_running, eng_stop}, 2'b00);
        rd(3, "R9 tc status", 2);
        @(negedge clk); #1; eng_tc = 1;
        tick(1); eng_tc = 0;
        wr(3, 2);
        rd(3, "R9 idle tc ignored", 0);
        wr(0, 32'h0000_0181);
        wr(2, 1);
        chk("R5 write start", {eng_start, eng_fill_req}, 2'b10);
        chk("R5 write fill", 32'(eng_load_fill), 64);
        wr(2, 0);
        chk("R6 forced stop", {eng_stop, eng_running}, 2'b10);
        tick(1);
        wr(2, 0);
        chk("R7 stop idle ignored", 32'(eng_stop), 0);
        wr(0, 32'h0300_0000);
        chk("R11 window off", 32'(win_sel), 0);
        tick(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule